// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned WIDTH-bit operands one bit at a time and produces a 2·WIDTH-bit product. A small controller steps a datapath that holds a carry bit, an accumulator, a multiplicand register, a combined multiplier/product register and an iteration counter. Each multiplier bit takes two clock cycles. In the first cycle the multiplicand is added to the accumulator when the current low multiplier bit is 1, and the counter always steps down. In the second cycle carry, accumulator and multiplier/product register shift right together as one word.

The controller has three named states. READY_WAIT is the idle state, ACCUM_STEP is the add state and ALIGN_STEP is the shift state. Its transitions are:
- START_ACCEPT: READY_WAIT to ACCUM_STEP when start is high. The operands are captured in this transition.
- HOLD: READY_WAIT stays in READY_WAIT while start is low.
- STEP_ADVANCE: ACCUM_STEP to ALIGN_STEP, always.
- LOOP_BACK: ALIGN_STEP to ACCUM_STEP while the counter is nonzero.
- FINISH: ALIGN_STEP to READY_WAIT once the counter is zero.
- RECOVER: any unused state code goes to READY_WAIT.

The parameter ONE_HOT picks the state-register encoding. With ONE_HOT=0 the encoding is binary: READY_WAIT=00, ACCUM_STEP=01, ALIGN_STEP=10. With ONE_HOT=1 it is one-hot: READY_WAIT=100, ACCUM_STEP=010, ALIGN_STEP=001. A user pulses start while ready is high and reads the product once ready returns high.

Top module: `shift_add_mul`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) puts the block in READY_WAIT with ready=1 and product=0.
- R2: For every pair of unsigned operands, product equals mcand × mplier once ready has returned high after an operation. The upper WIDTH bits of product hold the accumulator and the lower WIDTH bits hold the shifted multiplier register.
- R3: start sampled high while ready=1 captures the operands at that edge and drops ready in the next cycle. ready then stays low for exactly 2·WIDTH cycles and returns high. ready falls only through START_ACCEPT.
- R4: start is ignored while ready=0: pulsing it during an operation changes neither the result nor the completion cycle.
- R5: Changes of mcand and mplier after the capturing edge have no effect on the running operation.
- R6: While ready=1 and start=0, product and ready hold their values regardless of operand inputs.
- R7: Both settings of ONE_HOT give identical port behaviour, and at most one of the load, shift and decrement strobes is active in any cycle.
- R8: If start is held high when an operation finishes, ready is high for exactly one cycle and the next operation begins with the operands present in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when sampled high in READY_WAIT |
| mcand | input | WIDTH | Unsigned multiplicand |
| mplier | input | WIDTH | Unsigned multiplier |
| product | output | 2*WIDTH | {accumulator, multiplier/product register} |
| ready | output | 1 | High in READY_WAIT |

## Verification
The bench builds two copies with WIDTH=4, one with ONE_HOT=0 and one with ONE_HOT=1, and drives both with the same stimulus. A width of four keeps the operand space at 256 pairs, so every product, every carry out of the accumulator (up to 15 × 15), and every count from WIDTH down to zero is covered in a sweep of a few thousand cycles. The sweep also pulses start and scrambles the operands during some operations, and it runs a back-to-back case with start held high.

// File: rtl/mul_pkg.sv
package mul_pkg;

    typedef enum logic [1:0] {
        READY_WAIT = 2'b00,
        ACCUM_STEP = 2'b01,
        ALIGN_STEP = 2'b10,
        BAD_CODE   = 2'b11
    } phase_t;

    typedef struct packed {
        logic load;
        logic add;
        logic shift;
        logic decr;
    } strobe_t;

endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl #(
    parameter bit ONE_HOT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              q_lsb,
    input  logic              cnt_zero,
    output mul_pkg::strobe_t  stb,
    output logic              ready
);
    import mul_pkg::*;

    phase_t cur_ph;
    phase_t nxt_ph;

    generate
        if (ONE_HOT) begin : g_onehot
            logic [2:0] st_q;
            logic [2:0] st_d;

            always_comb begin
                unique case (nxt_ph)
                    ACCUM_STEP: st_d = 3'b010;
                    ALIGN_STEP: st_d = 3'b001;
                    default:    st_d = 3'b100;
                endcase
            end

            always_ff @(posedge clk) begin
                if (rst) st_q <= 3'b100;
                else     st_q <= st_d;
            end

            always_comb begin
                case (st_q)
                    3'b100:  cur_ph = READY_WAIT;
                    3'b010:  cur_ph = ACCUM_STEP;
                    3'b001:  cur_ph = ALIGN_STEP;
                    default: cur_ph = BAD_CODE;
                endcase
            end
        end else begin : g_binary
            logic [1:0] st_q;

            always_ff @(posedge clk) begin
                if (rst) st_q <= READY_WAIT;
                else     st_q <= nxt_ph;
            end

            assign cur_ph = phase_t'(st_q);
        end
    endgenerate

    // Transitions
    always_comb begin
        unique case (cur_ph)
            READY_WAIT: nxt_ph = start ? ACCUM_STEP : READY_WAIT;
            ACCUM_STEP: nxt_ph = ALIGN_STEP;
            ALIGN_STEP: nxt_ph = cnt_zero ? READY_WAIT : ACCUM_STEP;
            BAD_CODE:   nxt_ph = READY_WAIT;
        endcase
    end

    // Strobes
    always_comb begin
        stb   = '0;
        ready = 1'b0;
        unique case (cur_ph)
            READY_WAIT: begin
                ready    = 1'b1;
                stb.load = start;
            end
            ACCUM_STEP: begin
                stb.decr = 1'b1;
                stb.add  = q_lsb;
            end
            ALIGN_STEP: stb.shift = 1'b1;
            BAD_CODE:   stb = '0;
        endcase
    end

endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
    parameter int WIDTH = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  mul_pkg::strobe_t     stb,
    input  logic [WIDTH-1:0]     mcand,
    input  logic [WIDTH-1:0]     mplier,
    output logic                 q_lsb,
    output logic                 cnt_zero,
    output logic [2*WIDTH-1:0]   product
);
    localparam int CW = $clog2(WIDTH + 1);

    logic             c_q;
    logic [WIDTH-1:0] a_q;
    logic [WIDTH-1:0] b_q;
    logic [WIDTH-1:0] q_q;
    logic [CW-1:0]    p_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= 1'b0;
            a_q <= '0;
            b_q <= '0;
            q_q <= '0;
            p_q <= '0;
        end else begin
            if (stb.load) begin
                c_q <= 1'b0;
                a_q <= '0;
                b_q <= mcand;
                q_q <= mplier;
                p_q <= CW'(WIDTH);
            end
            if (stb.add) begin
                {c_q, a_q} <= {1'b0, a_q} + {1'b0, b_q};
            end
            if (stb.decr) begin
                p_q <= p_q - 1'b1;
            end
            if (stb.shift) begin
                {c_q, a_q, q_q} <= {1'b0, c_q, a_q, q_q[WIDTH-1:1]};
            end
        end
    end

    assign q_lsb    = q_q[0];
    assign cnt_zero = (p_q == '0);
    assign product  = {a_q, q_q};

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
    parameter int WIDTH   = 8,
    parameter bit ONE_HOT = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [WIDTH-1:0]     mcand,
    input  logic [WIDTH-1:0]     mplier,
    output logic [2*WIDTH-1:0]   product,
    output logic                 ready
);
    mul_pkg::strobe_t stb;
    logic             q_lsb;
    logic             cnt_zero;

    mul_ctrl #(.ONE_HOT(ONE_HOT)) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .q_lsb    (q_lsb),
        .cnt_zero (cnt_zero),
        .stb      (stb),
        .ready    (ready)
    );

    mul_datapath #(.WIDTH(WIDTH)) dp_i (
        .clk      (clk),
        .rst      (rst),
        .stb      (stb),
        .mcand    (mcand),
        .mplier   (mplier),
        .q_lsb    (q_lsb),
        .cnt_zero (cnt_zero),
        .product  (product)
    );

endmodule

// File: rtl/mul_chk.sv
module mul_chk #(
    parameter int WIDTH = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               ready,
    input logic [2*WIDTH-1:0] product,
    input mul_pkg::strobe_t   stb
);
    localparam int BW = $clog2(2 * WIDTH + 1) + 1;

    logic [BW-1:0] busy_n;

    always_ff @(posedge clk) begin
        if (rst || ready) busy_n <= '0;
        else              busy_n <= busy_n + 1'b1;
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> ready);

    p_start_launch_r3: assert property (@(posedge clk) disable iff (rst)
        ready && start |=> !ready);

    p_fall_needs_start_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> $past(start));

    p_busy_len_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> busy_n == BW'(2 * WIDTH));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        ready && !start |=> ready && $stable(product));

    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stb.load, stb.decr, stb.shift}));

endmodule

bind shift_add_mul mul_chk #(.WIDTH(WIDTH)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .ready   (ready),
    .product (product),
    .stb     (stb)
);

// File: tb/shift_add_mul_tb_top.sv
module shift_add_mul_tb_top;
    localparam int W = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [W-1:0]   mc = '0;
    logic [W-1:0]   mp = '0;
    logic [2*W-1:0] prod_b, prod_o;
    logic           rdy_b, rdy_o;
    int             total = 0;
    int             bad = 0;
    bit             done = 1'b0;

    always #5 clk = ~clk;

    shift_add_mul #(.WIDTH(W), .ONE_HOT(1'b0)) dut_i (
        .clk(clk), .rst(rst), .start(start), .mcand(mc), .mplier(mp),
        .product(prod_b), .ready(rdy_b)
    );

    shift_add_mul #(.WIDTH(W), .ONE_HOT(1'b1)) dut_oh_i (
        .clk(clk), .rst(rst), .start(start), .mcand(mc), .mplier(mp),
        .product(prod_o), .ready(rdy_o)
    );

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Checks both encodings; the one-hot copy also carries R7
    task automatic chk_rdy(string req, int exp);
        chk(req, "ready binary", int'(rdy_b), exp);
        chk({req, " R7"}, "ready onehot", int'(rdy_o), exp);
    endtask

    task automatic chk_prod(string req, int exp);
        chk(req, "product binary", int'(prod_b), exp);
        chk({req, " R7"}, "product onehot", int'(prod_o), exp);
    endtask

    task automatic run_op(int a, int b, bit scramble);
        @(negedge clk);
        mc = W'(a); mp = W'(b); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk_rdy("R3 launch", 0);
        for (int k = 1; k < 2 * W; k++) begin
            if (scramble && k == 1) begin
                mc = W'(~a); mp = W'(~b); start = 1'b1;  // R4 R5 stimulus
            end
            if (scramble && k == 3) start = 1'b0;
            @(negedge clk);
        end
        chk_rdy("R3 still busy", 0);
        @(negedge clk);
        chk_rdy(scramble ? "R3 R4 done" : "R3 done", 1);
        chk_prod(scramble ? "R2 R4 R5" : "R2", a * b);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk_rdy("R1", 1);
        chk_prod("R1", 0);
        rst = 1'b0;

        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                run_op(a, b, ((a + b) % 5) == 0);
            end
        end

        // R6: idle with start low ignores operand changes
        mc = 4'd3; mp = 4'd9;
        repeat (4) @(negedge clk);
        chk_rdy("R6", 1);
        chk_prod("R6", 15 * 15);

        // R8: start held high across completion
        mc = 4'd5; mp = 4'd6; start = 1'b1;
        @(negedge clk);
        chk_rdy("R8 first launch", 0);
        repeat (2 * W - 1) @(negedge clk);
        chk_rdy("R8 first busy", 0);
        @(negedge clk);
        chk_rdy("R8 first done", 1);
        chk_prod("R8 first", 30);
        mc = 4'd9; mp = 4'd13;
        @(negedge clk);
        chk_rdy("R8 one-cycle ready", 0);
        start = 1'b0;
        repeat (2 * W - 1) @(negedge clk);
        chk_rdy("R8 second busy", 0);
        @(negedge clk);
        chk_rdy("R8 second done", 1);
        chk_prod("R8 second", 117);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule